// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receiving end of the monitor-channel handshake carried on a time-division control bus. The frame logic around it raises a one-cycle frame strobe once per frame. In that cycle it presents the monitor byte taken from the downstream slot and the downstream handshake bit. Both are ignored in every other cycle. The block drives the upstream acknowledge bit, hands each byte it accepts to an internal consumer, and flags the end of a message and any aborted transfer.

Both handshake bits are active low. A byte counts as received only when the same value arrives, with the downstream bit active, in two frames in a row. Once the block has accepted a byte, it pulls the acknowledge low. The sender then frees the downstream bit for one frame and the block releases the acknowledge. After that the sender either offers the next byte or keeps the bit free for a second frame, which ends the message. A byte that does not repeat where a new byte is due aborts the transfer, and so does a byte that changes while it is being acknowledged.

Accepted bytes leave on a valid/ready stream. The output holds one byte. `out_valid` stays high and `out_data` stays fixed until the cycle in which `out_ready` is high. Back-pressure never drops or overwrites a byte. While a byte is still held, the receiver does not release the acknowledge, so the sender cannot offer another byte.

Top module: `gcim_rx`

## Requirements
- R1: After reset, `mr_n` is 1 and `out_valid`, `eom` and `abort_ind` are 0.
- R2: While idle, `mr_n` stays 1 for frames with `mx_n`=1. The first frame with `mx_n`=0 drives `mr_n` to 0.
- R3: A byte is accepted when frames in a row carry the same `mon_byte` with `mx_n`=0. At the second of these frames `out_valid` rises with that byte on `out_data`. A first byte that changes between frames is not accepted, and the block waits for a repeat.
- R4: After an accepted byte, a frame with `mx_n`=1 sets `mr_n` to 1. A following byte with `mx_n`=0 in two frames in a row is accepted as in R3, and `mr_n` returns to 0.
- R5: After an accepted byte, two frames in a row with `mx_n`=1 raise `eom` for exactly one cycle, with `mr_n`=1. The block is then idle.
- R6: If an expected new byte differs in its second frame with `mx_n`=0, `abort_ind` pulses for one cycle, `mr_n` becomes 1 and nothing is output. The block stays aborted while `mx_n`=0, and returns to idle at the first frame with `mx_n`=1.
- R7: While a byte is being acknowledged, a frame with `mx_n`=0 and a different `mon_byte` causes the abort of R6.
- R8: `out_valid` stays high with `out_data` stable until the cycle in which `out_ready` is 1. Each accepted byte is presented exactly once, so a byte taken at once gives a one-cycle pulse. While the byte is still held, frames with `mx_n`=1 keep `mr_n` at 0. No end of message is reported. The first frame after the byte is taken sets `mr_n` to 1.
- R9: With `frame_stb`=0, `mx_n` and `mon_byte` have no effect on `mr_n` or on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe marking the frame's monitor slot |
| mon_byte | input | DATA_W | Monitor byte received downstream |
| mx_n | input | 1 | Downstream handshake bit, active low |
| mr_n | output | 1 | Upstream acknowledge bit, active low |
| out_valid | output | 1 | Accepted byte available |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_data | output | DATA_W | Accepted byte |
| eom | output | 1 | One-cycle end-of-message pulse |
| abort_ind | output | 1 | One-cycle abort pulse |

## Verification
Every result of a frame is registered at the clock edge that samples `frame_stb`. So `mr_n`, `out_valid`, `out_data`, `eom` and `abort_ind` are due one edge after the strobe. The pulses are gone one edge later unless a new frame or load intervenes. The bench applies each frame for one cycle from a falling edge and samples at the following falling edge. It samples again one cycle later to confirm that a pulse has ended or that a held byte persists. It clears `out_valid` by raising `out_ready` for exactly one edge, and reads the result at the next falling edge.

// File: rtl/gcim_pkg.sv
package gcim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_VALID = 3'd2,
    ST_NEW   = 3'd3,
    ST_NTH   = 3'd4,
    ST_WAIT  = 3'd5,
    ST_ABORT = 3'd6
  } gmr_state_e;

  function automatic logic ack_level(input gmr_state_e s);
    // active-low acknowledge: released in idle, new-byte, nth and abort
    case (s)
      ST_FIRST, ST_VALID, ST_WAIT: ack_level = 1'b0;
      default:                     ack_level = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/gcim_lastlook.sv
module gcim_lastlook #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] mon_byte,
  output logic              same_q
);
  logic [DATA_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_q <= '0;
    else if (frame_stb) prev_q <= mon_byte;
  end

  assign same_q = (mon_byte == prev_q);
endmodule

// File: rtl/gcim_fsm.sv
module gcim_fsm
  import gcim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic mx_act,
  input  logic same_q,
  input  logic slot_busy,
  output logic mr_n,
  output logic accept,
  output logic eom,
  output logic abort_ind
);
  gmr_state_e st_q, st_d;
  logic       acc_d, eom_d;

  always_comb begin
    st_d  = st_q;
    acc_d = 1'b0;
    eom_d = 1'b0;
    if (frame_stb) begin
      case (st_q)
        ST_IDLE:  if (mx_act) st_d = ST_FIRST;
        ST_FIRST: begin
          if (!mx_act) st_d = ST_IDLE;
          else if (same_q && !slot_busy) begin
            st_d  = ST_VALID;
            acc_d = 1'b1;
          end
        end
        ST_VALID: begin
          if (mx_act && !same_q) st_d = ST_ABORT;
          else if (!mx_act)      st_d = slot_busy ? ST_WAIT : ST_NEW;
        end
        ST_WAIT:  if (!slot_busy) st_d = ST_NEW;
        ST_NEW: begin
          if (mx_act) st_d = ST_NTH;
          else begin
            st_d  = ST_IDLE;
            eom_d = 1'b1;
          end
        end
        ST_NTH: begin
          if (mx_act && same_q) begin
            if (!slot_busy) begin
              st_d  = ST_VALID;
              acc_d = 1'b1;
            end
          end else st_d = ST_ABORT;
        end
        ST_ABORT: if (!mx_act) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      eom       <= 1'b0;
      abort_ind <= 1'b0;
    end else begin
      st_q      <= st_d;
      eom       <= eom_d;
      abort_ind <= (st_d == ST_ABORT) && (st_q != ST_ABORT);
    end
  end

  assign accept = acc_d;
  assign mr_n   = ack_level(st_q);

  a_r3_accept_needs_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (same_q && mx_act && frame_stb));
  a_r5_eom_released: assert property (@(posedge clk) disable iff (!rst_n)
    eom |-> mr_n);
  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ind |=> !abort_ind);
  a_r9_ack_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mr_n) |-> $past(frame_stb));
endmodule

// File: rtl/gcim_outbuf.sv
module gcim_outbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              slot_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign slot_busy = out_valid && !out_ready;

  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(out_valid && !out_ready));
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid);
endmodule

// File: rtl/gcim_rx.sv
module gcim_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] mon_byte,
  input  logic              mx_n,
  output logic              mr_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              eom,
  output logic              abort_ind
);
  logic same_q, accept, slot_busy;

  gcim_lastlook #(.DATA_W(DATA_W)) u_ll (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .mon_byte(mon_byte), .same_q(same_q)
  );

  gcim_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mx_act(!mx_n),
    .same_q(same_q), .slot_busy(slot_busy), .mr_n(mr_n),
    .accept(accept), .eom(eom), .abort_ind(abort_ind)
  );

  gcim_outbuf #(.DATA_W(DATA_W)) u_ob (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(mon_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .slot_busy(slot_busy)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (mr_n && !out_valid && !eom && !abort_ind));
  a_r6_abort_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ind |-> !accept);
endmodule

// File: tb/gcim_rx_bench.sv
module gcim_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] mon_byte = 8'h00;
  logic       mx_n = 1'b1;
  logic       out_ready = 1'b1;
  logic       mr_n, out_valid, eom, abort_ind;
  logic [7:0] out_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gcim_rx u_gcim_rx (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mon_byte(mon_byte),
    .mx_n(mx_n), .mr_n(mr_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .eom(eom), .abort_ind(abort_ind)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one frame: strobe for one edge, return at the following falling edge
  task automatic frame(input logic mx, input logic [7:0] b);
    mx_n = mx; mon_byte = b; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    mx_n = ~mx; mon_byte = ~b;
  endtask

  task automatic idle_cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "mr_n", mr_n, 1); chk("R1", "out_valid", out_valid, 0);
    chk("R1", "eom", eom, 0);   chk("R1", "abort_ind", abort_ind, 0);
  endtask

  task automatic t_basic();
    frame(1'b1, 8'h00); chk("R2", "mr_n idle", mr_n, 1);
    frame(1'b0, 8'hA5); chk("R2", "mr_n first", mr_n, 0);
    chk("R3", "no valid on first", out_valid, 0);
    frame(1'b0, 8'hA5); chk("R3", "valid", out_valid, 1);
    chk("R3", "data", out_data, 8'hA5);
    idle_cyc();         chk("R8", "single pulse", out_valid, 0);
    frame(1'b1, 8'hA5); chk("R4", "mr_n release", mr_n, 1);
    frame(1'b0, 8'h3C); chk("R4", "mr_n nth", mr_n, 1);
    chk("R4", "no valid nth", out_valid, 0);
    frame(1'b0, 8'h3C); chk("R4", "valid", out_valid, 1);
    chk("R4", "data", out_data, 8'h3C); chk("R4", "mr_n ack", mr_n, 0);
    frame(1'b1, 8'h3C); chk("R5", "no early eom", eom, 0);
    frame(1'b1, 8'h3C); chk("R5", "eom", eom, 1); chk("R5", "mr_n", mr_n, 1);
    idle_cyc();         chk("R5", "eom one cycle", eom, 0);
  endtask

  task automatic t_first_mismatch();
    frame(1'b0, 8'h11);
    frame(1'b0, 8'h22); chk("R3", "mismatch no valid", out_valid, 0);
    chk("R3", "mismatch still acked", mr_n, 0);
    frame(1'b0, 8'h22); chk("R3", "repeat valid", out_valid, 1);
    chk("R3", "repeat data", out_data, 8'h22);
    frame(1'b1, 8'h22); frame(1'b1, 8'h22);
  endtask

  task automatic t_abort();
    frame(1'b0, 8'h55); frame(1'b0, 8'h55);
    frame(1'b1, 8'h55);
    frame(1'b0, 8'h66);
    frame(1'b0, 8'h67); chk("R6", "abort", abort_ind, 1);
    chk("R6", "mr_n", mr_n, 1); chk("R6", "no valid", out_valid, 0);
    frame(1'b0, 8'h67); chk("R6", "abort pulse ends", abort_ind, 0);
    chk("R6", "held mr_n", mr_n, 1); chk("R6", "held no valid", out_valid, 0);
    frame(1'b1, 8'h67); chk("R6", "idle mr_n", mr_n, 1);
    frame(1'b0, 8'h09); chk("R6", "restart mr_n", mr_n, 0);
    frame(1'b0, 8'h09); chk("R6", "restart valid", out_valid, 1);
    frame(1'b1, 8'h09); frame(1'b1, 8'h09);
  endtask

  task automatic t_changed();
    frame(1'b0, 8'h05); frame(1'b0, 8'h05);
    frame(1'b0, 8'h06); chk("R7", "abort", abort_ind, 1);
    chk("R7", "mr_n", mr_n, 1);
    frame(1'b1, 8'h06);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    frame(1'b0, 8'h77); frame(1'b0, 8'h77);
    idle_cyc(); idle_cyc();
    chk("R8", "held valid", out_valid, 1); chk("R8", "held data", out_data, 8'h77);
    frame(1'b1, 8'h77); chk("R8", "wait mr_n", mr_n, 0);
    frame(1'b1, 8'h77); chk("R8", "wait mr_n 2", mr_n, 0);
    chk("R8", "no eom while held", eom, 0);
    out_ready = 1'b1; idle_cyc();
    chk("R8", "taken", out_valid, 0);
    frame(1'b1, 8'h77); chk("R8", "release after take", mr_n, 1);
    frame(1'b1, 8'h77); chk("R8", "eom after take", eom, 1);
  endtask

  task automatic t_gate();
    mx_n = 1'b0; mon_byte = 8'hEE;
    repeat (4) idle_cyc();
    chk("R9", "mr_n ungated", mr_n, 1); chk("R9", "no valid", out_valid, 0);
    frame(1'b0, 8'h44);
    mx_n = 1'b0; mon_byte = 8'h44;
    repeat (3) idle_cyc();
    chk("R9", "no valid without frame", out_valid, 0);
    mx_n = 1'b1;
    repeat (3) idle_cyc();
    chk("R9", "mr_n held", mr_n, 0);
    frame(1'b1, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_cyc();
    t_basic();
    t_first_mismatch();
    t_abort();
    t_changed();
    t_backpressure();
    t_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule